// File: doc/BRIEF.md
# Mode-Switchable Bang-Bang Digital PLL Core

This block is the digital core of a clock recovery loop that ties an ADC sampling clock, made by an external voltage-controlled crystal oscillator, to a machine reference clock. Both clocks arrive as one-cycle strobes in the core's own clock domain, one strobe per rising edge. A feedback divider turns the sampling-clock strobes into a square level, and a reference divider turns the reference strobes into sampling ticks. A three-sample bang-bang detector compares the two. A proportional-integral filter turns the detector's early/late verdicts into a code for the DAC that steers the oscillator.

In lock the loop holds the sampling rate at fs = M·fref/(2N). A mode input picks the ratio pair. Synchronous mode uses a fixed M and N = 1, which gives 169 samples per reference period. Off-tune mode derives M = 169·K + 1 and N = K/2 from a command-loaded factor K. This offsets the sampling rate from the integer multiple by fref/K. The mode can be switched at any time. A lock flag reports when the detector has stopped drifting.

Top module: `dpll_core`

## Requirements
- R1: While rst_ni is low and after its release: dac_o is mid-scale (2^(DAC_W-1)), k_o is K_DEF (256), pd_o is 0 and locked_o is 0.
- R2: With mode_i = 0 (synchronous), div_m_o equals SYNC_M (338 by default) and div_n_o equals 1, in the same cycle as mode_i.
- R3: With mode_i = 1 (off-tune), div_m_o equals 169·k_o + 1 and div_n_o equals k_o/2 in the same cycle; for K = 256 this is 43265 and 128.
- R4: A k_load_i strobe updates k_o to k_i on the next cycle only if k_i is even and within K_MIN..K_MAX (118..2221). Otherwise k_o, div_m_o and div_n_o are left unchanged.
- R5: The feedback divider inverts its square level on every div_m_o-th fb_pulse_i. The reference divider makes a sampling tick on every div_n_o-th ref_pulse_i. Each divider wraps as soon as its count reaches or exceeds the current limit minus one.
- R6: Each tick samples the feedback level. Every second tick closes a window (A, T, B): A is the last sample of the previous window (0 after reset), T is the middle sample, and B is the sample taken at this tick. On the next cycle pd_o shows 3'b100 (early) if A≠T and T=B, 3'b001 (late) if A=T and T≠B, and 3'b010 otherwise. In all other cycles pd_o is 0.
- R7: One cycle after a nonzero pd_o, the integrator moves by +1 (early), by −1 (late) or by 0. It saturates at ±(2^(DAC_W-1)−1). dac_o becomes mid-scale + integrator + KP·direction, clamped to 0..2^DAC_W−1. dac_o holds otherwise.
- R8: locked_o rises one cycle after the LOCK_N-th consecutive verdict whose running net direction stays within ±LOCK_WIN. A verdict that pushes the running sum outside this window clears locked_o and restarts the count.
- R9: A run-time mode change applies the new ratios immediately. A divider whose count already lies past the new limit wraps on its next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | One-cycle strobe per reference clock edge |
| fb_pulse_i | input | 1 | One-cycle strobe per sampling clock edge |
| mode_i | input | 1 | 0 = synchronous, 1 = off-tune |
| k_i | input | K_W (12) | Offset factor to be loaded |
| k_load_i | input | 1 | Load strobe for k_i |
| k_o | output | K_W (12) | Offset factor in use |
| div_m_o | output | M_W (19) | Feedback divider ratio in use |
| div_n_o | output | N_W (11) | Reference divider ratio in use |
| pd_o | output | 3 | Detector verdict strobe {early, hold, late} |
| dac_o | output | DAC_W (16) | Oscillator control code |
| locked_o | output | 1 | Lock indication |

## Verification
The divider ratios follow mode_i and k_o in the same cycle. k_o changes one cycle after an accepted load strobe. pd_o appears one cycle after the cycle that carries the window-closing tick, and dac_o and locked_o follow one cycle after that verdict. The bench drives inputs one nanosecond after each rising edge, advances a behavioural model of these latencies on the same rising edge, and compares every output at the falling edge. This places each sample after all registers on the path have settled. Directed phases steer the loop into steady hold, both integrator rails, mode switching with dividers in mid-count, and legal and illegal K loads. A pseudo-random phase follows them.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  typedef enum logic [2:0] {
    PD_NONE = 3'b000,
    PD_LAG  = 3'b001,
    PD_HOLD = 3'b010,
    PD_LEAD = 3'b100
  } pd_e;
endpackage

// File: rtl/dpll_cfg.sv
module dpll_cfg #(
  parameter int K_W    = 12,
  parameter int K_MIN  = 118,
  parameter int K_MAX  = 2221,
  parameter int K_DEF  = 256,
  parameter int RATIO  = 169,
  parameter int SYNC_M = 338,
  parameter int M_W    = 19,
  parameter int N_W    = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mode_i,
  input  logic [K_W-1:0] k_i,
  input  logic           k_load_i,
  output logic [K_W-1:0] k_o,
  output logic [M_W-1:0] m_lim_o,
  output logic [N_W-1:0] n_lim_o
);
  logic [K_W-1:0] k_q;
  logic           k_ok;

  assign k_ok = !k_i[0] && (k_i >= K_W'(K_MIN)) && (k_i <= K_W'(K_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              k_q <= K_W'(K_DEF);
    else if (k_load_i && k_ok) k_q <= k_i;
  end

  assign k_o     = k_q;
  assign m_lim_o = mode_i ? (M_W'(RATIO) * M_W'(k_q) + M_W'(1)) : M_W'(SYNC_M);
  assign n_lim_o = mode_i ? N_W'(k_q >> 1) : N_W'(1);
endmodule

// File: rtl/dpll_div.sv
module dpll_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pulse_i,
  input  logic [W-1:0] lim_i,
  output logic         term_o
);
  logic [W-1:0] cnt_q;

  // >= keeps the count bounded when the limit shrinks mid-count
  assign term_o = pulse_i && (cnt_q >= lim_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (pulse_i) cnt_q <= term_o ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/dpll_bbpd.sv
module dpll_bbpd
  import dpll_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fb_term_i,
  input  logic       tick_i,
  output logic [2:0] pd_o
);
  logic       lvl_q;
  logic [1:0] smp_q;
  logic       ph_q;
  pd_e        pd_q;
  logic       s_a, s_t, s_b, early, late;

  assign s_a   = smp_q[1];
  assign s_t   = smp_q[0];
  assign s_b   = lvl_q;
  assign early = (s_a != s_t) && (s_t == s_b);
  assign late  = (s_a == s_t) && (s_t != s_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      smp_q <= '0;
      ph_q  <= 1'b0;
      pd_q  <= PD_NONE;
    end else begin
      if (fb_term_i) lvl_q <= ~lvl_q;
      if (tick_i) begin
        smp_q <= {smp_q[0], lvl_q};
        ph_q  <= ~ph_q;
      end
      if (tick_i && ph_q) pd_q <= early ? PD_LEAD : (late ? PD_LAG : PD_HOLD);
      else                pd_q <= PD_NONE;
    end
  end

  assign pd_o = pd_q;
endmodule

// File: rtl/dpll_loop.sv
module dpll_loop
  import dpll_pkg::*;
#(
  parameter int DAC_W    = 16,
  parameter int KP       = 64,
  parameter int LOCK_N   = 1024,
  parameter int LOCK_WIN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       pd_i,
  output logic [DAC_W-1:0] dac_o,
  output logic             locked_o
);
  localparam int SW = DAC_W + 3;
  localparam int RW = (LOCK_N > 1) ? $clog2(LOCK_N) : 1;
  localparam int DW = $clog2(LOCK_WIN + 1) + 2;
  localparam logic signed [SW-1:0] IMAX_S = SW'(2 ** (DAC_W - 1) - 1);
  localparam logic signed [SW-1:0] MID_S  = SW'(2 ** (DAC_W - 1));
  localparam logic signed [SW-1:0] DMAX_S = SW'(2 ** DAC_W - 1);
  localparam logic signed [SW-1:0] KP_S   = SW'(KP);
  localparam logic signed [DW-1:0] WIN_S  = DW'(LOCK_WIN);

  logic signed [SW-1:0] integ_q, dir, raw, integ_n, prop, sum;
  logic signed [DW-1:0] drift_q, drift_n;
  logic [RW-1:0]        run_q;
  logic [DAC_W-1:0]     dac_q, dac_n;
  logic                 lock_q, act;

  always_comb begin
    act     = (pd_i != PD_NONE);
    dir     = (pd_i == PD_LEAD) ? SW'(1) : ((pd_i == PD_LAG) ? -SW'(1) : '0);
    prop    = (pd_i == PD_LEAD) ? KP_S   : ((pd_i == PD_LAG) ? -KP_S   : '0);
    raw     = integ_q + dir;
    integ_n = (raw > IMAX_S) ? IMAX_S : ((raw < -IMAX_S) ? -IMAX_S : raw);
    sum     = MID_S + integ_n + prop;
    if (sum < 0)           dac_n = '0;
    else if (sum > DMAX_S) dac_n = DMAX_S[DAC_W-1:0];
    else                   dac_n = sum[DAC_W-1:0];
    drift_n = drift_q + dir[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= '0;
      dac_q   <= MID_S[DAC_W-1:0];
      drift_q <= '0;
      run_q   <= '0;
      lock_q  <= 1'b0;
    end else if (act) begin
      integ_q <= integ_n;
      dac_q   <= dac_n;
      if (drift_n > WIN_S || drift_n < -WIN_S) begin
        drift_q <= '0;
        run_q   <= '0;
        lock_q  <= 1'b0;
      end else if (run_q == RW'(LOCK_N - 1)) begin
        drift_q <= '0;
        run_q   <= '0;
        lock_q  <= 1'b1;
      end else begin
        drift_q <= drift_n;
        run_q   <= run_q + RW'(1);
      end
    end
  end

  assign dac_o    = dac_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/dpll_core.sv
module dpll_core #(
  parameter int K_W      = 12,
  parameter int K_MIN    = 118,
  parameter int K_MAX    = 2221,
  parameter int K_DEF    = 256,
  parameter int RATIO    = 169,
  parameter int SYNC_M   = 338,
  parameter int DAC_W    = 16,
  parameter int KP       = 64,
  parameter int LOCK_N   = 1024,
  parameter int LOCK_WIN = 8,
  localparam int M_W     = $clog2(RATIO * K_MAX + 2),
  localparam int N_W     = $clog2(K_MAX / 2 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_pulse_i,
  input  logic             fb_pulse_i,
  input  logic             mode_i,
  input  logic [K_W-1:0]   k_i,
  input  logic             k_load_i,
  output logic [K_W-1:0]   k_o,
  output logic [M_W-1:0]   div_m_o,
  output logic [N_W-1:0]   div_n_o,
  output logic [2:0]       pd_o,
  output logic [DAC_W-1:0] dac_o,
  output logic             locked_o
);
  logic [M_W-1:0] m_lim;
  logic [N_W-1:0] n_lim;
  logic           fb_term, tick;

  dpll_cfg #(
    .K_W(K_W), .K_MIN(K_MIN), .K_MAX(K_MAX), .K_DEF(K_DEF),
    .RATIO(RATIO), .SYNC_M(SYNC_M), .M_W(M_W), .N_W(N_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .k_i(k_i),
    .k_load_i(k_load_i), .k_o(k_o), .m_lim_o(m_lim), .n_lim_o(n_lim)
  );

  dpll_div #(.W(M_W)) u_fb_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(fb_pulse_i), .lim_i(m_lim), .term_o(fb_term)
  );

  dpll_div #(.W(N_W)) u_ref_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(ref_pulse_i), .lim_i(n_lim), .term_o(tick)
  );

  dpll_bbpd u_pd (
    .clk_i(clk_i), .rst_ni(rst_ni), .fb_term_i(fb_term), .tick_i(tick), .pd_o(pd_o)
  );

  dpll_loop #(
    .DAC_W(DAC_W), .KP(KP), .LOCK_N(LOCK_N), .LOCK_WIN(LOCK_WIN)
  ) u_loop (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_i(pd_o), .dac_o(dac_o), .locked_o(locked_o)
  );

  assign div_m_o = m_lim;
  assign div_n_o = n_lim;
endmodule

// File: rtl/dpll_core_chk.sv
module dpll_core_chk #(
  parameter int K_W   = 12,
  parameter int K_MIN = 118,
  parameter int K_MAX = 2221,
  parameter int DAC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             k_load_i,
  input logic [K_W-1:0]   k_o,
  input logic [2:0]       pd_o,
  input logic [DAC_W-1:0] dac_o,
  input logic             locked_o
);
  assert_pd_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pd_o));

  assert_pd_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_o != 3'b000) |=> (pd_o == 3'b000));

  assert_dac_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_o == 3'b000) |=> $stable(dac_o));

  assert_k_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !k_load_i |=> $stable(k_o));

  assert_k_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !k_o[0] && (k_o >= K_W'(K_MIN)) && (k_o <= K_W'(K_MAX)));

  assert_lock_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> ($past(pd_o) != 3'b000));
endmodule

bind dpll_core dpll_core_chk #(
  .K_W(K_W), .K_MIN(K_MIN), .K_MAX(K_MAX), .DAC_W(DAC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .k_load_i(k_load_i), .k_o(k_o),
  .pd_o(pd_o), .dac_o(dac_o), .locked_o(locked_o)
);

// File: tb/dpll_core_bench.sv
`timescale 1ns/1ps
module dpll_core_bench;
  localparam int K_W = 12, K_MIN = 118, K_MAX = 2221, K_DEF = 256, RATIO = 169;
  localparam int SYNC_M = 2, DAC_W = 10, KP = 16, LOCK_N = 64, LOCK_WIN = 4;
  localparam int M_W = $clog2(RATIO * K_MAX + 2), N_W = $clog2(K_MAX / 2 + 1);
  localparam int IMAX = 2 ** (DAC_W - 1) - 1, MID = 2 ** (DAC_W - 1), DMAX = 2 ** DAC_W - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, ref_p = 1'b0, fb_p = 1'b0, mode = 1'b0, k_ld = 1'b0;
  logic [K_W-1:0]   k_in = '0;
  logic [K_W-1:0]   k_o;
  logic [M_W-1:0]   div_m;
  logic [N_W-1:0]   div_n;
  logic [2:0]       pd;
  logic [DAC_W-1:0] dac;
  logic             locked;

  dpll_core #(
    .K_W(K_W), .K_MIN(K_MIN), .K_MAX(K_MAX), .K_DEF(K_DEF), .RATIO(RATIO),
    .SYNC_M(SYNC_M), .DAC_W(DAC_W), .KP(KP), .LOCK_N(LOCK_N), .LOCK_WIN(LOCK_WIN)
  ) u_dpll_core (
    .clk_i(clk), .rst_ni(rst_n), .ref_pulse_i(ref_p), .fb_pulse_i(fb_p), .mode_i(mode),
    .k_i(k_in), .k_load_i(k_ld), .k_o(k_o), .div_m_o(div_m), .div_n_o(div_n),
    .pd_o(pd), .dac_o(dac), .locked_o(locked)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0, r9_win = 0;

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // behavioural reference: integers and a sample history queue
  int mk, mfc, mrc, mlvl, mph, mpd, minteg, mdac, mdrift, mrun, mlock;
  int hist[$];

  function automatic int sat(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk = K_DEF; mfc = 0; mrc = 0; mlvl = 0; mph = 0; mpd = 0;
      minteg = 0; mdac = MID; mdrift = 0; mrun = 0; mlock = 0;
      hist = '{0, 0};
    end else begin
      int mlim, nlim, dir, nd, a, t, b;
      bit tk;
      mlim = mode ? RATIO * mk + 1 : SYNC_M;
      nlim = mode ? mk / 2 : 1;
      tk   = ref_p && (mrc >= nlim - 1);
      if (mpd != 0) begin
        dir    = (mpd == 4) ? 1 : ((mpd == 1) ? -1 : 0);
        minteg = sat(minteg + dir, -IMAX, IMAX);
        mdac   = sat(MID + minteg + KP * dir, 0, DMAX);
        nd     = mdrift + dir;
        if (nd > LOCK_WIN || nd < -LOCK_WIN) begin mdrift = 0; mrun = 0; mlock = 0; end
        else if (mrun == LOCK_N - 1)         begin mdrift = 0; mrun = 0; mlock = 1; end
        else                                  begin mdrift = nd; mrun++; end
      end
      mpd = 0;
      if (tk) begin
        if (mph == 1) begin
          a = hist[0]; t = hist[1]; b = mlvl;
          mpd = (a != t && t == b) ? 4 : ((a == t && t != b) ? 1 : 2);
        end
        void'(hist.pop_front());
        hist.push_back(mlvl);
        mph ^= 1;
      end
      if (fb_p) begin
        if (mfc >= mlim - 1) begin mfc = 0; mlvl ^= 1; end else mfc++;
      end
      if (ref_p) mrc = (mrc >= nlim - 1) ? 0 : mrc + 1;
      if (k_ld && !k_in[0] && k_in >= K_MIN && k_in <= K_MAX) mk = int'(k_in);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 k_o", int'(k_o), mk);
      chk(mode ? "R3 div_m_o" : "R2 div_m_o", int'(div_m), mode ? RATIO * mk + 1 : SYNC_M);
      chk(mode ? "R3 div_n_o" : "R2 div_n_o", int'(div_n), mode ? mk / 2 : 1);
      chk(r9_win ? "R9 pd_o" : "R5 R6 pd_o", int'(pd), mpd);
      chk(r9_win ? "R9 dac_o" : "R7 dac_o", int'(dac), mdac);
      chk("R8 locked_o", int'(locked), mlock);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic kload(int v, int exp_k);
    k_in = K_W'(v); k_ld = 1'b1;
    cyc(1);
    k_ld = 1'b0;
    @(negedge clk);
    chk("R4 load", int'(k_o), exp_k);
    cyc(1);
  endtask

  initial begin
    #(200000 * 5);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [15:0] lf;
    int rail;
    cyc(2);
    @(negedge clk);
    chk("R1 dac_o reset", int'(dac), MID);
    chk("R1 k_o reset", int'(k_o), K_DEF);
    chk("R1 pd_o reset", int'(pd), 0);
    chk("R1 locked_o reset", int'(locked), 0);
    cyc(1);
    rst_n = 1'b1;
    cyc(1);
    @(negedge clk);
    chk("R1 dac_o after release", int'(dac), MID);
    chk("R2 sync m", int'(div_m), SYNC_M);
    chk("R2 sync n", int'(div_n), 1);
    cyc(1);
    mode = 1'b1;
    @(negedge clk);
    chk("R3 default m", int'(div_m), 43265);
    chk("R3 default n", int'(div_n), 128);
    cyc(1);
    // R4: illegal loads rejected, legal ones taken
    kload(117, 256);
    kload(2222, 256);
    kload(257, 256);
    kload(2223, 256);
    kload(300, 300);
    @(negedge clk);
    chk("R3 k300 m", int'(div_m), 50701);
    chk("R3 k300 n", int'(div_n), 150);
    cyc(1);
    kload(118, 118);
    kload(2220, 2220);
    kload(256, 256);
    @(negedge clk);
    chk("R4 ratios after reload", int'(div_m), 43265);
    cyc(1);
    mode = 1'b0;

    // R8: static feedback level gives hold verdicts and lock
    ref_p = 1'b1; fb_p = 1'b0;
    cyc(200);
    @(negedge clk);
    chk("R8 lock after steady hold", int'(locked), 1);
    cyc(1);

    // R7: persistent one-sided verdicts drive the integrator to a rail
    fb_p = 1'b1;
    cyc(1500);
    @(negedge clk);
    rail = int'(dac);
    chk("R7 rail reached", int'(rail == 0 || rail == DMAX), 1);
    chk("R8 lock lost", int'(locked), 0);
    cyc(1);
    fb_p = 1'b0;
    cyc(1);
    fb_p = 1'b1;
    cyc(2500);
    @(negedge clk);
    chk("R7 opposite rail", int'(dac), DMAX - rail);
    cyc(1);

    // R9: shrink the feedback limit while its count is mid-way
    r9_win = 1;
    fb_p = 1'b0; ref_p = 1'b0;
    mode = 1'b1;
    fb_p = 1'b1;
    cyc(10);
    mode = 1'b0;
    ref_p = 1'b1;
    cyc(40);
    r9_win = 0;

    // pseudo-random traffic over both modes and K loads
    lf = 16'hACE1;
    for (int i = 0; i < 20000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ref_p = lf[0];
      fb_p  = lf[3] | lf[7];
      if (lf[11:4] == 8'h00) mode = ~mode;
      k_ld = (lf[15:9] == 7'h05);
      k_in = {lf[12:2], lf[1] & lf[5]};
      cyc(1);
    end
    k_ld = 1'b0;
    cyc(4);
    report();
  end
endmodule